// File: doc/BRIEF.md
# UART Channel Interrupt Controller

This block gathers the interrupt causes of one serial channel into a four-bit source register. A mask register removes individual causes, and a pending register combines the two. The design drives one interrupt line. The receive and transmit FIFOs sit outside the block and present only their occupancy counts. The block compares each count with a threshold taken from a 3-bit field of the FIFO control word. The multiplier applied to that field is fixed at build time by the channel number.

Software clears causes by writing ones. A write to the pending register acts on pending and source in the same clock. A write to the source register clears only the source, and pending follows one clock later. In FIFO mode the block also reports when the receive condition is met, so that the receive timeout logic can cancel a running timeout.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `src_q`, `pnd_q` and the mask are zero, and `irq` and `rx_to_cancel` are low.
- R2: The transmit level is `fifo_ctrl[10:8]` times M. The receive level is (`fifo_ctrl[6:4]` + 1) times M. M is 32 for CHANNEL 0, 8 for CHANNEL 1 or 4, and 2 for CHANNEL 2 or 3. For any other channel both levels are 0.
- R3: With FIFO mode on (`fifo_ctrl[0]` = 1), source bit 2 (transmit) is set at the next edge in any cycle where `tx_count` is less than or equal to the transmit level.
- R4: With FIFO mode on, source bit 0 (receive) is set at the next edge, and `rx_to_cancel` is high for the following cycle, in either of two cases: `rx_count` is at or above the receive level, or `rx_count` is non-zero while `rx_to_en` is low.
- R5: With FIFO mode off, source bit 0 is set at the next edge whenever `rx_ready` is high, and the FIFO counts have no effect on any source bit.
- R6: `err_evt` sets source bit 1 and `modem_evt` sets source bit 3 at the next edge.
- R7: A `pnd_wr` write clears the bits of `wr_data` that are 1 in both `src_q` and `pnd_q` at the same edge. `irq` follows at that edge.
- R8: A `src_wr` write clears the bits of `wr_data` that are 1 in `src_q` only. `pnd_q` keeps them for one more cycle.
- R9: When a source bit is cleared and its set condition holds in the same cycle, the set wins and the bit stays 1.
- R10: `pnd_q` equals `src_q` AND NOT mask as they stood one cycle earlier, except for bits being cleared by R7. `irq` is high exactly when `pnd_q` is non-zero.
- R11: A `msk_wr` write loads the mask from `wr_data`. A masked source bit never reaches `pnd_q`, and clearing the mask bit lets it through one cycle after the mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_ctrl | input | 11 | FIFO control word: bit 0 FIFO mode, [6:4] receive field, [10:8] transmit field |
| rx_to_en | input | 1 | Receive timeout feature enabled |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_ready | input | 1 | Receive data ready (used in non-FIFO mode) |
| err_evt | input | 1 | Error cause strobe |
| modem_evt | input | 1 | Modem cause strobe |
| pnd_wr | input | 1 | Write-one-to-clear strobe for the pending register |
| src_wr | input | 1 | Write-one-to-clear strobe for the source register |
| msk_wr | input | 1 | Mask register load strobe |
| wr_data | input | 4 | Write data for the three strobes |
| src_q | output | 4 | Source register |
| pnd_q | output | 4 | Pending register |
| irq | output | 1 | Interrupt line |
| rx_to_cancel | output | 1 | Receive timeout cancel strobe |

## Verification
A source bit can be cleared by a write in the same cycle that its level condition sets it again. This happens when the transmit count sits at its trigger level. The bench provokes the case by holding the count there and issuing a pending-register clear on that bit. It then checks three things: the source bit stays set, the pending bit drops for exactly one cycle, and the pending bit returns on the following cycle. The other case is a mask release while the source bit is held. The bench checks that pending reappears one cycle after the mask changes, not at the same edge.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int SRC_W = 4;
  localparam int B_RX  = 0;
  localparam int B_ERR = 1;
  localparam int B_TX  = 2;
  localparam int B_MDM = 3;

  // multiplier applied to a trigger field; zero for unsupported channels
  function automatic int chan_mult(input int ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/uirq_trig_level.sv
module uirq_trig_level #(
  parameter int CHANNEL = 0,
  parameter int OFFSET  = 0,
  parameter int LVL_W   = 10
) (
  input  logic [2:0]       fld,
  output logic [LVL_W-1:0] level
);
  localparam int MULT = uirq_pkg::chan_mult(CHANNEL);

  logic [LVL_W-1:0] fld_x;
  assign fld_x = LVL_W'(fld) + LVL_W'(OFFSET);

  generate
    if (MULT == 0) begin : g_zero
      assign level = '0;
    end else begin : g_scale
      assign level = fld_x * LVL_W'(MULT);
    end
  endgenerate
endmodule

// File: rtl/uirq_src_reg.sv
module uirq_src_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  // set is applied after clear so a live condition survives a clear
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/uirq_out.sv
module uirq_out #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic [W-1:0] msk,
  input  logic [W-1:0] pclr,
  output logic [W-1:0] pnd,
  output logic         irq
);
  logic [W-1:0] pnd_d;
  assign pnd_d = src & ~msk & ~pclr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pnd <= '0;
      irq <= 1'b0;
    end else begin
      pnd <= pnd_d;
      irq <= |pnd_d;
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [10:0]      fifo_ctrl,
  input  logic             rx_to_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             rx_ready,
  input  logic             err_evt,
  input  logic             modem_evt,
  input  logic             pnd_wr,
  input  logic             src_wr,
  input  logic             msk_wr,
  input  logic [3:0]       wr_data,
  output logic [3:0]       src_q,
  output logic [3:0]       pnd_q,
  output logic             irq,
  output logic             rx_to_cancel
);
  import uirq_pkg::*;

  localparam int LVL_W = (CNT_W > 9) ? CNT_W + 1 : 10;

  logic             fifo_on;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic [LVL_W-1:0] tx_cnt_x, rx_cnt_x;
  logic             tx_hit, rx_hit, rx_set;
  logic [SRC_W-1:0] set_vec, clr_vec, pclr, msk_q;

  assign fifo_on  = fifo_ctrl[0];
  assign tx_cnt_x = LVL_W'(tx_count);
  assign rx_cnt_x = LVL_W'(rx_count);

  uirq_trig_level #(.CHANNEL(CHANNEL), .OFFSET(0), .LVL_W(LVL_W)) u_tx_lvl (
    .fld(fifo_ctrl[10:8]), .level(tx_lvl));

  uirq_trig_level #(.CHANNEL(CHANNEL), .OFFSET(1), .LVL_W(LVL_W)) u_rx_lvl (
    .fld(fifo_ctrl[6:4]), .level(rx_lvl));

  assign tx_hit = fifo_on && (tx_cnt_x <= tx_lvl);
  assign rx_hit = fifo_on && (((rx_count != '0) && !rx_to_en) || (rx_cnt_x >= rx_lvl));
  assign rx_set = rx_hit || (!fifo_on && rx_ready);

  always_comb begin
    set_vec        = '0;
    set_vec[B_RX]  = rx_set;
    set_vec[B_ERR] = err_evt;
    set_vec[B_TX]  = tx_hit;
    set_vec[B_MDM] = modem_evt;
  end

  assign pclr    = pnd_wr ? wr_data : '0;
  assign clr_vec = pclr | (src_wr ? wr_data : '0);

  uirq_src_reg #(.W(SRC_W)) u_src (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .q(src_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      msk_q        <= '0;
      rx_to_cancel <= 1'b0;
    end else begin
      if (msk_wr) msk_q <= wr_data;
      rx_to_cancel <= rx_hit;
    end
  end

  uirq_out #(.W(SRC_W)) u_out (
    .clk(clk), .rst(rst), .src(src_q), .msk(msk_q), .pclr(pclr),
    .pnd(pnd_q), .irq(irq));
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int CNT_W = 8,
  parameter int LVL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [10:0]      fifo_ctrl,
  input logic             rx_to_en,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count,
  input logic             rx_ready,
  input logic             err_evt,
  input logic             src_wr,
  input logic             pnd_wr,
  input logic [3:0]       wr_data,
  input logic [3:0]       src_q,
  input logic [3:0]       pnd_q,
  input logic [3:0]       msk_q,
  input logic             irq,
  input logic             rx_to_cancel,
  input logic [LVL_W-1:0] tx_lvl,
  input logic [LVL_W-1:0] rx_lvl
);
  assert_tx_level_R3: assert property (@(posedge clk) disable iff (rst)
    (fifo_ctrl[0] && (LVL_W'(tx_count) <= tx_lvl)) |=> src_q[2]);

  assert_rx_level_R4: assert property (@(posedge clk) disable iff (rst)
    (fifo_ctrl[0] && (LVL_W'(rx_count) >= rx_lvl)) |=> (src_q[0] && rx_to_cancel));

  assert_rx_no_timeout_R4: assert property (@(posedge clk) disable iff (rst)
    (fifo_ctrl[0] && !rx_to_en && (rx_count != '0)) |=> (src_q[0] && rx_to_cancel));

  assert_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (!fifo_ctrl[0] && rx_ready) |=> src_q[0]);

  assert_src_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (src_wr && wr_data[1] && !err_evt) |=> !src_q[1]);

  assert_pnd_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (pnd_wr && wr_data[3]) |=> !pnd_q[3]);

  assert_irq_any_R10: assert property (@(posedge clk) disable iff (rst)
    irq == (pnd_q != 4'b0));

  assert_masked_R11: assert property (@(posedge clk) disable iff (rst)
    (pnd_q & $past(msk_q)) == 4'b0);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .fifo_ctrl(fifo_ctrl), .rx_to_en(rx_to_en),
  .rx_count(rx_count), .tx_count(tx_count), .rx_ready(rx_ready),
  .err_evt(err_evt), .src_wr(src_wr), .pnd_wr(pnd_wr), .wr_data(wr_data),
  .src_q(src_q), .pnd_q(pnd_q), .msk_q(msk_q), .irq(irq),
  .rx_to_cancel(rx_to_cancel), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl));

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [10:0] fifo_ctrl = '0;
  logic rx_to_en = 1'b0;
  logic [CNT_W-1:0] rx_count = '0, tx_count = '0;
  logic rx_ready = 1'b0, err_evt = 1'b0, modem_evt = 1'b0;
  logic pnd_wr = 1'b0, src_wr = 1'b0, msk_wr = 1'b0;
  logic [3:0] wr_data = '0;

  logic [3:0] src0, pnd0, src2, pnd2, src5, pnd5;
  logic irq0, irq2, irq5, can0, can2, can5;

  always #5 clk = ~clk;

  uart_irq_ctrl #(.CHANNEL(0), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .fifo_ctrl(fifo_ctrl), .rx_to_en(rx_to_en),
    .rx_count(rx_count), .tx_count(tx_count), .rx_ready(rx_ready),
    .err_evt(err_evt), .modem_evt(modem_evt), .pnd_wr(pnd_wr), .src_wr(src_wr),
    .msk_wr(msk_wr), .wr_data(wr_data), .src_q(src0), .pnd_q(pnd0), .irq(irq0),
    .rx_to_cancel(can0));

  uart_irq_ctrl #(.CHANNEL(2), .CNT_W(CNT_W)) u_ch2 (
    .clk(clk), .rst(rst), .fifo_ctrl(fifo_ctrl), .rx_to_en(rx_to_en),
    .rx_count(rx_count), .tx_count(tx_count), .rx_ready(rx_ready),
    .err_evt(err_evt), .modem_evt(modem_evt), .pnd_wr(pnd_wr), .src_wr(src_wr),
    .msk_wr(msk_wr), .wr_data(wr_data), .src_q(src2), .pnd_q(pnd2), .irq(irq2),
    .rx_to_cancel(can2));

  uart_irq_ctrl #(.CHANNEL(5), .CNT_W(CNT_W)) u_ch5 (
    .clk(clk), .rst(rst), .fifo_ctrl(fifo_ctrl), .rx_to_en(rx_to_en),
    .rx_count(rx_count), .tx_count(tx_count), .rx_ready(rx_ready),
    .err_evt(err_evt), .modem_evt(modem_evt), .pnd_wr(pnd_wr), .src_wr(src_wr),
    .msk_wr(msk_wr), .wr_data(wr_data), .src_q(src5), .pnd_q(pnd5), .irq(irq5),
    .rx_to_cancel(can5));

  // scoreboard
  typedef struct {
    string      rq;
    int         sel;
    logic [3:0] m;
    logic [3:0] e;
  } item_t;

  item_t sb[$];
  item_t it;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [3:0] pick(input int sel);
    case (sel)
      0: return src0;
      1: return pnd0;
      2: return {3'b0, irq0};
      3: return {3'b0, can0};
      4: return src2;
      default: return src5;
    endcase
  endfunction

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      it = sb.pop_front();
      n_vec++;
      if ((pick(it.sel) & it.m) !== (it.e & it.m)) begin
        n_bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.rq, it.sel,
                 pick(it.sel) & it.m, it.e & it.m);
      end
    end
  end

  task automatic expect_v(input string rq, input int sel, input logic [3:0] m,
                          input logic [3:0] e);
    item_t x;
    x.rq = rq; x.sel = sel; x.m = m; x.e = e;
    sb.push_back(x);
  endtask

  task automatic nxt();
    @(negedge clk); #1;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic strobes_off();
    pnd_wr = 0; src_wr = 0; msk_wr = 0; err_evt = 0; modem_evt = 0; wr_data = '0;
  endtask

  task automatic clear_all();
    nxt(); src_wr = 1; wr_data = 4'hF; cyc();
    nxt(); strobes_off(); cyc();
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cyc(); cyc();
    expect_v("R1 src", 0, 4'hF, 4'h0);
    expect_v("R1 pnd", 1, 4'hF, 4'h0);
    expect_v("R1 irq", 2, 4'h1, 4'h0);
    expect_v("R1 cancel", 3, 4'h1, 4'h0);
    nxt(); rst = 0; cyc();
    expect_v("R1 after release src", 0, 4'hF, 4'h0);
    expect_v("R1 after release irq", 2, 4'h1, 4'h0);

    // R5: non-FIFO mode, rx_ready sets receive bit, tx count 0 ignored
    nxt(); rx_ready = 1; tx_count = 0; rx_count = 8'd200; cyc();
    expect_v("R5 rx from ready", 0, 4'hF, 4'h1);
    expect_v("R10 pending lags", 1, 4'hF, 4'h0);
    expect_v("R5 no cancel", 3, 4'h1, 4'h0);
    nxt(); rx_ready = 0; cyc();
    expect_v("R10 pending follows", 1, 4'hF, 4'h1);
    expect_v("R10 irq high", 2, 4'h1, 4'h1);

    // R7: pending write clears both at the same edge
    nxt(); pnd_wr = 1; wr_data = 4'h1; cyc();
    expect_v("R7 src cleared", 0, 4'hF, 4'h0);
    expect_v("R7 pnd cleared", 1, 4'hF, 4'h0);
    expect_v("R7 irq low", 2, 4'h1, 4'h0);
    nxt(); strobes_off(); rx_count = 0;

    // R6 / R8: error cause, then source-only clear
    err_evt = 1; cyc();
    expect_v("R6 error bit", 0, 4'hF, 4'h2);
    nxt(); strobes_off(); cyc();
    expect_v("R6 error pending", 1, 4'hF, 4'h2);
    nxt(); src_wr = 1; wr_data = 4'h2; cyc();
    expect_v("R8 src cleared", 0, 4'hF, 4'h0);
    expect_v("R8 pnd kept", 1, 4'hF, 4'h2);
    nxt(); strobes_off(); cyc();
    expect_v("R8 pnd follows", 1, 4'hF, 4'h0);
    expect_v("R8 irq low", 2, 4'h1, 4'h0);

    // R11: mask blocks modem cause, release lets it through
    nxt(); msk_wr = 1; wr_data = 4'h8; cyc();
    nxt(); strobes_off(); modem_evt = 1; cyc();
    expect_v("R6 modem bit", 0, 4'hF, 4'h8);
    nxt(); strobes_off(); cyc();
    expect_v("R11 masked pnd", 1, 4'hF, 4'h0);
    expect_v("R11 masked irq", 2, 4'h1, 4'h0);
    nxt(); msk_wr = 1; wr_data = 4'h0; cyc();
    expect_v("R11 release not same edge", 1, 4'hF, 4'h0);
    nxt(); strobes_off(); cyc();
    expect_v("R11 unmasked pnd", 1, 4'hF, 4'h8);
    expect_v("R11 unmasked irq", 2, 4'h1, 4'h1);
    nxt(); pnd_wr = 1; wr_data = 4'h8; cyc();
    nxt(); strobes_off();

    // R2 / R3: FIFO mode, transmit field 1
    fifo_ctrl = 11'h101; rx_to_en = 1; rx_count = 0; tx_count = 8'd40;
    clear_all();
    nxt(); tx_count = 8'd3; cyc();
    expect_v("R3 ch0 tx 3<=32", 0, 4'h4, 4'h4);
    expect_v("R2 ch2 tx 3>2", 4, 4'h4, 4'h0);
    expect_v("R2 ch5 tx level 0", 5, 4'h4, 4'h0);
    nxt(); tx_count = 8'd2; cyc();
    expect_v("R2 ch2 tx 2<=2", 4, 4'h4, 4'h4);
    nxt(); tx_count = 8'd40; clear_all();
    nxt(); tx_count = 8'd33; cyc();
    expect_v("R2 ch0 tx 33 above", 0, 4'h4, 4'h0);
    nxt(); tx_count = 8'd32; cyc();
    expect_v("R3 ch0 tx 32 at level", 0, 4'h4, 4'h4);
    nxt(); cyc();

    // R9: clear collides with live set condition
    nxt(); pnd_wr = 1; wr_data = 4'h4; cyc();
    expect_v("R9 src held", 0, 4'h4, 4'h4);
    expect_v("R9 pnd dropped", 1, 4'hF, 4'h0);
    expect_v("R9 irq dropped", 2, 4'h1, 4'h0);
    nxt(); strobes_off(); cyc();
    expect_v("R9 pnd back", 1, 4'hF, 4'h4);
    nxt(); tx_count = 8'd0; cyc();
    expect_v("R2 ch5 tx 0<=0", 5, 4'h4, 4'h4);

    // R4: receive field 1 gives 64 on channel 0
    nxt(); fifo_ctrl = 11'h111; tx_count = 8'd40; rx_count = 0; rx_to_en = 1;
    clear_all();
    nxt(); rx_count = 8'd63; cyc();
    expect_v("R4 rx 63 below", 0, 4'hF, 4'h0);
    expect_v("R4 no cancel", 3, 4'h1, 4'h0);
    nxt(); rx_count = 8'd64; cyc();
    expect_v("R4 rx 64 at level", 0, 4'h1, 4'h1);
    expect_v("R4 cancel", 3, 4'h1, 4'h1);
    nxt(); rx_count = 0; rx_to_en = 0; clear_all();
    nxt(); rx_count = 8'd1; cyc();
    expect_v("R4 timeout off nonzero", 0, 4'h1, 4'h1);
    expect_v("R4 cancel timeout off", 3, 4'h1, 4'h1);
    nxt(); rx_to_en = 1; clear_all();
    expect_v("R4 timeout on one byte", 0, 4'hF, 4'h0);
    expect_v("R4 no cancel timeout on", 3, 4'h1, 4'h0);

    nxt(); nxt();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule